// File: doc/BRIEF.md
# Dual-Channel UART Sleep Controller

This block decides when each of two UART channels may power down, and it wakes them again. Each channel has its own enable bit in an 8-bit sleep configuration byte. An enabled channel goes to sleep once it has been quiet for two consecutive cycles. Quiet means:
- no interrupt is pending for it;
- its receive line is at its idle level;
- its modem-input status nibble is zero.

When every channel is asleep, the shared oscillator-enable output drops.

While a channel sleeps, any of three events wakes it: a start-bit edge on its receive line, a byte load into its transmitter, or any set bit in its modem-status delta nibble. On wake the controller does the following:
- It raises the oscillator enable again in the same cycle.
- It raises a per-channel wake interrupt that reports no real pending cause.
- If the oscillator had been off, it holds a ready flag low for a fixed settling count.

Once software clears the wake interrupt and the channel is quiet again, the channel returns to sleep on its own. This repeats until software clears the channel's enable bit. Clearing that bit forces the channel awake without a wake interrupt.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: After reset no channel is asleep, no wake interrupt is set, and osc_en and ready are both 1.
- R2: A channel whose enable bit (bit i of sleep_cfg for channel i) is 1 sets its asleep flag at the second clock edge of an unbroken run of cycles in which all of the following hold. The flag is never set after only one such cycle.
  - its int_pend bit is 0;
  - its wake interrupt is 0;
  - its receive line is idle;
  - bits [3:0] of its 8-bit msr slice are all zero.
- R3: The receive line counts as idle when it is 1 with the channel's irda bit 0, and when it is 0 with irda 1.
- R4: A sleeping channel wakes on a receive start edge: 1 to 0 when irda is 0, 0 to 1 when irda is 1.
- R5: A sleeping channel also wakes on a tx_load pulse, or when any of bits [7:4] of its msr slice is 1.
- R6: A wake event clears the channel's asleep flag at the next edge and sets its wake_irq. The interrupt stays set until a wake_clr pulse. Once it is cleared and the R2 conditions hold again, the channel goes back to sleep without any further action.
- R7: osc_en is 0 only while every channel is asleep and none has a wake event or a cleared enable bit in the current cycle. Such an event raises osc_en combinationally in that same cycle.
- R8: ready is 0 while all channels are asleep. When the all-asleep state ends at a clock edge, ready stays 0 until 32 further edges have passed, then becomes 1.
- R9: A wake event in the cycle in which a channel would enter sleep blocks the entry. The channel stays awake with no wake interrupt.
- R10: Clearing a sleeping channel's enable bit wakes it at the next edge without setting wake_irq.
- R11: Bits of sleep_cfg at positions 2 through 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (runs from the crystal, not gated by osc_en) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_cfg | input | 8 | Sleep enable byte, bit i for channel i |
| irda | input | 2 | Per-channel infrared line polarity select |
| rx | input | 2 | Per-channel receive line |
| int_pend | input | 2 | Per-channel pending interrupt from the UART |
| msr | input | 16 | Modem status, 8 bits per channel (channel i in [8i+7:8i]) |
| tx_load | input | 2 | Per-channel transmitter byte-load pulse |
| wake_clr | input | 2 | Per-channel wake interrupt clear pulse |
| asleep | output | 2 | Per-channel sleep flag |
| wake_irq | output | 2 | Per-channel wake interrupt |
| osc_en | output | 1 | Shared oscillator enable |
| ready | output | 1 | Device settled and usable |

## Verification
Two pairs of functions can collide in one cycle. The first is sleep entry against a wake event. The bench arms a channel with one quiet cycle and then pulses tx_load in exactly the cycle in which entry would complete; it expects the flag to stay low, no interrupt, and entry two edges after the pulse ends. The second pair is the combinational oscillator restart against the registered sleep flags. Each wake kind is applied on each channel while both sleep. osc_en is sampled within the wake cycle, before any edge, and ready is then counted edge by edge to its 32nd.

// File: rtl/uart_sleep_pkg.sv
package uart_sleep_pkg;

    localparam int MSR_W = 8;

    typedef struct packed {
        logic asleep;
        logic armed;
        logic rx_prev;
        logic wake_irq;
    } chan_state_t;

endpackage

// File: rtl/uart_sleep_chan.sv
module uart_sleep_chan
    import uart_sleep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             irda_i,
    input  logic             rx_i,
    input  logic             int_pend_i,
    input  logic [MSR_W-1:0] msr_i,
    input  logic             tx_load_i,
    input  logic             wake_clr_i,
    output logic             asleep_o,
    output logic             wake_irq_o,
    output logic             stay_o
);

    chan_state_t st_d, st_q;
    logic rx_idle, rx_start, wake_ev, idle_ok;

    always_comb begin
        rx_idle  = irda_i ? !rx_i : rx_i;
        rx_start = irda_i ? (!st_q.rx_prev && rx_i) : (st_q.rx_prev && !rx_i);
        wake_ev  = rx_start || tx_load_i || (|msr_i[MSR_W-1:MSR_W/2]);
        idle_ok  = en_i && !int_pend_i && !st_q.wake_irq && rx_idle
                   && (msr_i[MSR_W/2-1:0] == '0);

        st_d         = st_q;
        st_d.rx_prev = rx_i;
        if (wake_clr_i) st_d.wake_irq = 1'b0;

        if (st_q.asleep) begin
            st_d.armed = 1'b0;
            if (!en_i) begin
                st_d.asleep = 1'b0;
            end else if (wake_ev) begin
                st_d.asleep   = 1'b0;
                st_d.wake_irq = 1'b1;
            end
        end else begin
            st_d.armed  = idle_ok && !wake_ev;
            st_d.asleep = st_q.armed && idle_ok && !wake_ev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{asleep: 1'b0, armed: 1'b0, rx_prev: 1'b1, wake_irq: 1'b0};
        else        st_q <= st_d;
    end

    assign asleep_o   = st_q.asleep;
    assign wake_irq_o = st_q.wake_irq;
    assign stay_o     = st_q.asleep && en_i && !wake_ev;

    p_entry_needs_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.asleep) |-> $past(en_i && !int_pend_i && msr_i[MSR_W/2-1:0] == '0));

    p_wake_beats_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.asleep && tx_load_i) |=> !st_q.asleep);

    p_load_wakes_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.asleep && en_i && tx_load_i) |=> (!st_q.asleep && st_q.wake_irq));

    p_disable_wakes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.asleep && !en_i) |=> !st_q.asleep);

endmodule

// File: rtl/uart_sleep_settle.sv
module uart_sleep_settle #(
    parameter int SETTLE_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic all_asleep_i,
    input  logic leave_i,
    output logic ready_o
);

    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (all_asleep_i && leave_i)  cnt_d = CNT_W'(SETTLE_CYCLES);
        else if (cnt_q != '0)         cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready_o = !all_asleep_i && (cnt_q == '0);

    p_settle_starts_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (all_asleep_i && leave_i) |=> !ready_o);

endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl
    import uart_sleep_pkg::*;
#(
    parameter int NUM_CH        = 2,
    parameter int CFG_W         = 8,
    parameter int SETTLE_CYCLES = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CFG_W-1:0]        sleep_cfg,
    input  logic [NUM_CH-1:0]       irda,
    input  logic [NUM_CH-1:0]       rx,
    input  logic [NUM_CH-1:0]       int_pend,
    input  logic [NUM_CH*MSR_W-1:0] msr,
    input  logic [NUM_CH-1:0]       tx_load,
    input  logic [NUM_CH-1:0]       wake_clr,
    output logic [NUM_CH-1:0]       asleep,
    output logic [NUM_CH-1:0]       wake_irq,
    output logic                    osc_en,
    output logic                    ready
);

    logic [NUM_CH-1:0] stay;
    logic              all_asleep;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        uart_sleep_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (sleep_cfg[i]),
            .irda_i     (irda[i]),
            .rx_i       (rx[i]),
            .int_pend_i (int_pend[i]),
            .msr_i      (msr[i*MSR_W +: MSR_W]),
            .tx_load_i  (tx_load[i]),
            .wake_clr_i (wake_clr[i]),
            .asleep_o   (asleep[i]),
            .wake_irq_o (wake_irq[i]),
            .stay_o     (stay[i])
        );
    end

    assign all_asleep = &asleep;
    assign osc_en     = !(&stay);

    uart_sleep_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk          (clk),
        .rst_n        (rst_n),
        .all_asleep_i (all_asleep),
        .leave_i      (!(&stay)),
        .ready_o      (ready)
    );

    p_osc_off_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> all_asleep);

    p_ready_low_asleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        all_asleep |-> !ready);

endmodule

// File: tb/test_uart_sleep_ctrl.sv
module test_uart_sleep_ctrl;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sleep_cfg = '0;
    logic [1:0]  irda = '0, rx = 2'b11, int_pend = '0, tx_load = '0, wake_clr = '0;
    logic [15:0] msr = '0;
    logic [1:0]  asleep, wake_irq;
    logic        osc_en, ready;

    int total = 0;
    int bad   = 0;

    always #(PERIOD/2) clk = ~clk;

    uart_sleep_ctrl i_uart_sleep_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_cfg(sleep_cfg), .irda(irda), .rx(rx),
        .int_pend(int_pend), .msr(msr), .tx_load(tx_load), .wake_clr(wake_clr),
        .asleep(asleep), .wake_irq(wake_irq), .osc_en(osc_en), .ready(ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wake_case(input int ch, input int kind);
        @(negedge clk);
        sleep_cfg = 8'h00; wake_clr = 2'b11; tx_load = '0; msr = '0; int_pend = '0;
        irda = (kind == 1) ? 2'b11 : 2'b00;
        rx   = (kind == 1) ? 2'b00 : 2'b11;
        @(negedge clk);
        wake_clr = '0; sleep_cfg = 8'h03;
        @(negedge clk);
        @(negedge clk);
        chk("R2 both asleep", {30'd0, asleep}, 32'd3);
        chk("R7 osc off", {31'd0, osc_en}, 32'd0);
        chk("R8 ready low asleep", {31'd0, ready}, 32'd0);
        case (kind)
            0: rx[ch] = 1'b0;
            1: rx[ch] = 1'b1;
            2: tx_load[ch] = 1'b1;
            default: msr[ch*8 + 5] = 1'b1;
        endcase
        #1;
        chk("R7 osc on same cycle", {31'd0, osc_en}, 32'd1);
        @(negedge clk);
        tx_load = '0; msr = '0;
        rx = (kind == 1) ? 2'b00 : 2'b11;
        chk((kind < 2) ? "R4 rx edge wake" : "R5 load/delta wake",
            {30'd0, asleep}, 32'(2'b11 ^ (2'b01 << ch)));
        chk("R6 wake irq", {30'd0, wake_irq}, 32'(2'b01 << ch));
        repeat (31) @(negedge clk);
        chk("R8 ready low at 31", {31'd0, ready}, 32'd0);
        @(negedge clk);
        chk("R8 ready at 32", {31'd0, ready}, 32'd1);
        wake_clr[ch] = 1'b1;
        @(negedge clk);
        wake_clr = '0;
        chk("R6 irq cleared", {30'd0, wake_irq}, 32'd0);
        @(negedge clk);
        chk("R6 not yet back", {31'd0, asleep[ch]}, 32'd0);
        @(negedge clk);
        chk("R6 auto re-entry", {30'd0, asleep}, 32'd3);
        chk("R7 osc off again", {31'd0, osc_en}, 32'd0);
    endtask

    initial begin
        #(PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 asleep", {30'd0, asleep}, 32'd0);
        chk("R1 irq", {30'd0, wake_irq}, 32'd0);
        chk("R1 osc_en", {31'd0, osc_en}, 32'd1);
        chk("R1 ready", {31'd0, ready}, 32'd1);
        rst_n = 1'b1;

        // R2/R3 sweep over entry conditions of channel 0
        for (int c = 0; c < 32; c++) begin
            logic e;
            @(negedge clk);
            sleep_cfg = 8'h00;
            @(negedge clk);
            sleep_cfg   = {7'd0, c[0]};
            int_pend[0] = c[1];
            irda[0]     = c[2];
            rx[0]       = c[3];
            msr[3:0]    = c[4] ? 4'b0100 : 4'b0000;
            e = c[0] && !c[1] && (c[2] ? !c[3] : c[3]) && !c[4];
            @(negedge clk);
            chk("R2 not after one cycle", {31'd0, asleep[0]}, 32'd0);
            @(negedge clk);
            chk("R2/R3 entry sweep", {31'd0, asleep[0]}, {31'd0, e});
            chk("R2 no irq in sweep", {30'd0, wake_irq}, 32'd0);
        end

        // R11 upper config bits ignored
        @(negedge clk);
        sleep_cfg = 8'hFC; int_pend = '0; irda = '0; rx = 2'b11; msr = '0;
        repeat (4) @(negedge clk);
        chk("R11 upper bits", {30'd0, asleep}, 32'd0);
        chk("R11 osc on", {31'd0, osc_en}, 32'd1);

        // R9 wake beats entry
        @(negedge clk);
        sleep_cfg = 8'h01;
        @(negedge clk);
        tx_load[0] = 1'b1;
        @(negedge clk);
        tx_load[0] = 1'b0;
        chk("R9 entry blocked", {31'd0, asleep[0]}, 32'd0);
        chk("R9 no irq", {30'd0, wake_irq}, 32'd0);
        @(negedge clk);
        chk("R9 still armed only", {31'd0, asleep[0]}, 32'd0);
        @(negedge clk);
        chk("R9 entry after", {31'd0, asleep[0]}, 32'd1);

        for (int ch = 0; ch < 2; ch++)
            for (int k = 0; k < 4; k++)
                wake_case(ch, k);

        // R10 disable while asleep
        sleep_cfg = 8'h02;
        #1;
        chk("R10 osc on at disable", {31'd0, osc_en}, 32'd1);
        @(negedge clk);
        chk("R10 woken", {30'd0, asleep}, 32'd2);
        chk("R10 no irq", {30'd0, wake_irq}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R10 stays awake", {30'd0, asleep}, 32'd2);
        chk("R10 osc stays on", {31'd0, osc_en}, 32'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule